// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Width Decoder

This block measures the high time of eight servo-style pulse lines coming from a radio receiver. Each line has its own synchroniser, edge detector and capture logic, so pulses that overlap in time are measured correctly. This holds for starts only 17 µs apart, for ends that arrive in any channel order, and for several ends landing in the same clock cycle. All lines are timed against one free-running microsecond counter. That counter is derived from the system clock through a clock-enable prescaler.

When a line falls, the block stores the line's width in its own result register and sets its valid bit. It also checks where the fall landed against a common 60 µs grid and flags any fall that is not close to a grid boundary. A line that stays high too long, or that never rises for too long, is marked invalid and keeps its last good width. Once every line has finished, whether by a fall or by a timeout, a one-cycle frame-complete strobe tells a downstream bus controller that it may start its frame.

Top module: `rc_pulse_decoder`

## Requirements
- R1: For each of the NUM_CH channels, a good pulse stores width = (microsecond count at the fall) − (count at the rise), modulo 2^TS_W, into that channel's entry of `width_o`, and sets that channel's `valid_o` bit to 1.
- R2: Rises on different channels only 17 µs apart, while earlier pulses are still high, are each timed correctly.
- R3: On every good fall, `off_grid_o[i]` is set to 1 when the grid phase is greater than GRID_TOL_US and less than GRID_US − GRID_TOL_US, and is cleared to 0 otherwise. The grid phase is the microsecond count since reset, modulo GRID_US. The bit is held when a channel times out.
- R4: Results are stored per channel, whatever order the channels finish in.
- R5: Falls on several channels in the same microsecond are all captured, each with its own width.
- R6: A channel that stays high for more than MAX_HIGH_US microseconds counts as finished. Its valid bit clears, its width is held, and its later fall changes nothing.
- R7: A channel with no rise within RISE_TIMEOUT_US microseconds of its previous fall (or of reset) counts as finished. Its valid bit clears and its width is held.
- R8: `frame_done_o` pulses for exactly one cycle, once per frame, within two microseconds after the last channel finishes, and never before then. Completion state is cleared by the first rise of the next frame.
- R9: After reset, every width is 0, every valid bit is 0, every off-grid bit is 0, and `frame_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | NUM_CH | Raw asynchronous pulse lines, bit i is channel i |
| width_o | output | NUM_CH×TS_W | Measured width per channel in microseconds |
| valid_o | output | NUM_CH | Channel's latest result was a good pulse |
| off_grid_o | output | NUM_CH | Channel's latest good fall missed the grid |
| frame_done_o | output | 1 | One-cycle strobe when all channels have finished |

## Verification
The bench builds the block with CLK_PER_US = 4. At that setting the two-flop synchroniser delay stays under one microsecond, so every expected width is an exact integer the bench can compute from its own drive times. MAX_HIGH_US is lowered to 300 and RISE_TIMEOUT_US to 3000. This brings both timeout paths within a few thousand microseconds, so a stuck-high line and a missing line each fit inside one short frame, together with the width hold that follows. GRID_US stays at 60 with a tolerance of 2, so an end placed 10 µs past a boundary is flagged and ends on a boundary are not.

// File: rtl/rcpd_pkg.sv
package rcpd_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_HIGH  = 2'd1,
        CH_STUCK = 2'd2,
        CH_LOST  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/rcpd_timebase.sv
module rcpd_timebase #(
    parameter int CLK_PER_US = 50,
    parameter int TS_W       = 16,
    parameter int GRID_US    = 60,
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1,
    localparam int GW = $clog2(GRID_US)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            tick_o,
    output logic [TS_W-1:0] now_o,
    output logic [GW-1:0]   phase_o
);
    typedef struct packed {
        logic [PW-1:0]   presc;
        logic [TS_W-1:0] now;
        logic [GW-1:0]   phase;
    } tb_s;

    tb_s tb_d, tb_q;

    always_comb begin
        tb_d   = tb_q;
        tick_o = (tb_q.presc == PW'(CLK_PER_US - 1));
        if (tick_o) begin
            tb_d.presc = '0;
            tb_d.now   = tb_q.now + TS_W'(1);
            tb_d.phase = (tb_q.phase == GW'(GRID_US - 1)) ? '0 : tb_q.phase + GW'(1);
        end else begin
            tb_d.presc = tb_q.presc + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign now_o   = tb_q.now;
    assign phase_o = tb_q.phase;
endmodule

// File: rtl/rcpd_channel.sv
module rcpd_channel
    import rcpd_pkg::*;
#(
    parameter int TS_W            = 16,
    parameter int GRID_US         = 60,
    parameter int GRID_TOL_US     = 2,
    parameter int MAX_HIGH_US     = 3000,
    parameter int RISE_TIMEOUT_US = 25000,
    localparam int GW  = $clog2(GRID_US),
    localparam int LIM = (MAX_HIGH_US > RISE_TIMEOUT_US) ? MAX_HIGH_US : RISE_TIMEOUT_US,
    localparam int CW  = $clog2(LIM + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pulse_i,
    input  logic            tick_i,
    input  logic [TS_W-1:0] now_i,
    input  logic [GW-1:0]   phase_i,
    output logic [TS_W-1:0] width_o,
    output logic            valid_o,
    output logic            off_grid_o,
    output logic            fin_o,
    output logic            rise_o
);
    typedef struct packed {
        logic            s1;
        logic            s2;
        logic            lvl;
        ch_state_e       state;
        logic [CW-1:0]   cnt;
        logic [TS_W-1:0] rise_ts;
        logic [TS_W-1:0] width;
        logic            valid;
        logic            off_grid;
        logic            fin;
    } ch_s;

    ch_s ch_d, ch_q;
    logic rise, fall;

    always_comb begin
        ch_d     = ch_q;
        ch_d.fin = 1'b0;
        ch_d.s1  = pulse_i;
        ch_d.s2  = ch_q.s1;
        ch_d.lvl = ch_q.s2;
        rise     = ch_q.s2 & ~ch_q.lvl;
        fall     = ~ch_q.s2 & ch_q.lvl;
        unique case (ch_q.state)
            CH_IDLE, CH_LOST: begin
                if (rise) begin
                    ch_d.state   = CH_HIGH;
                    ch_d.rise_ts = now_i;
                    ch_d.cnt     = '0;
                end else if (ch_q.state == CH_IDLE && tick_i) begin
                    if (ch_q.cnt + CW'(1) >= CW'(RISE_TIMEOUT_US)) begin
                        ch_d.state = CH_LOST;
                        ch_d.valid = 1'b0;
                        ch_d.fin   = 1'b1;
                    end else begin
                        ch_d.cnt = ch_q.cnt + CW'(1);
                    end
                end
            end
            CH_HIGH: begin
                if (fall) begin
                    ch_d.state    = CH_IDLE;
                    ch_d.cnt      = '0;
                    ch_d.width    = now_i - ch_q.rise_ts;
                    ch_d.valid    = 1'b1;
                    ch_d.off_grid = (phase_i > GW'(GRID_TOL_US)) &&
                                    (phase_i < GW'(GRID_US - GRID_TOL_US));
                    ch_d.fin      = 1'b1;
                end else if (tick_i) begin
                    if (ch_q.cnt >= CW'(MAX_HIGH_US)) begin
                        ch_d.state = CH_STUCK;
                        ch_d.valid = 1'b0;
                        ch_d.fin   = 1'b1;
                    end else begin
                        ch_d.cnt = ch_q.cnt + CW'(1);
                    end
                end
            end
            CH_STUCK: begin
                if (fall) begin
                    ch_d.state = CH_IDLE;
                    ch_d.cnt   = '0;
                end
            end
            default: ch_d.state = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign width_o    = ch_q.width;
    assign valid_o    = ch_q.valid;
    assign off_grid_o = ch_q.off_grid;
    assign fin_o      = ch_q.fin;
    assign rise_o     = rise;
endmodule

// File: rtl/rcpd_frame.sv
module rcpd_frame #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fin_i,
    input  logic [NUM_CH-1:0] rise_i,
    output logic              frame_done_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic              done;
    } fr_s;

    fr_s fr_d, fr_q;
    logic all_q;
    logic [NUM_CH-1:0] base;

    always_comb begin
        all_q     = &fr_q.mask;
        base      = (all_q && |rise_i) ? '0 : fr_q.mask;
        fr_d.mask = base | fin_i;
        fr_d.done = (&fr_d.mask) && !all_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign frame_done_o = fr_q.done;
endmodule

// File: rtl/rc_pulse_decoder.sv
module rc_pulse_decoder #(
    parameter int NUM_CH          = 8,
    parameter int CLK_PER_US      = 50,
    parameter int TS_W            = 16,
    parameter int GRID_US         = 60,
    parameter int GRID_TOL_US     = 2,
    parameter int MAX_HIGH_US     = 3000,
    parameter int RISE_TIMEOUT_US = 25000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           pulse_in,
    output logic [NUM_CH-1:0][TS_W-1:0] width_o,
    output logic [NUM_CH-1:0]           valid_o,
    output logic [NUM_CH-1:0]           off_grid_o,
    output logic                        frame_done_o
);
    localparam int GW = $clog2(GRID_US);

    logic              tick;
    logic [TS_W-1:0]   now;
    logic [GW-1:0]     phase;
    logic [NUM_CH-1:0] fin;
    logic [NUM_CH-1:0] rise;

    rcpd_timebase #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W), .GRID_US(GRID_US)) u_time (
        .clk(clk), .rst_n(rst_n), .tick_o(tick), .now_o(now), .phase_o(phase)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        rcpd_channel #(
            .TS_W(TS_W), .GRID_US(GRID_US), .GRID_TOL_US(GRID_TOL_US),
            .MAX_HIGH_US(MAX_HIGH_US), .RISE_TIMEOUT_US(RISE_TIMEOUT_US)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .pulse_i(pulse_in[i]), .tick_i(tick),
            .now_i(now), .phase_i(phase), .width_o(width_o[i]), .valid_o(valid_o[i]),
            .off_grid_o(off_grid_o[i]), .fin_o(fin[i]), .rise_o(rise[i])
        );
    end

    rcpd_frame #(.NUM_CH(NUM_CH)) u_frame (
        .clk(clk), .rst_n(rst_n), .fin_i(fin), .rise_i(rise), .frame_done_o(frame_done_o)
    );
endmodule

// File: rtl/rcpd_checker.sv
module rcpd_checker #(
    parameter int NUM_CH = 8,
    parameter int TS_W   = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH-1:0]           fin,
    input logic [NUM_CH-1:0][TS_W-1:0] width,
    input logic [NUM_CH-1:0]           valid,
    input logic [NUM_CH-1:0]           off_grid,
    input logic                        frame_done
);
    // R8
    frame_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    frame_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(|fin));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4
        width_only_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (width[i] != $past(width[i])) |-> fin[i]);

        // R3
        grid_flag_only_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (off_grid[i] != $past(off_grid[i])) |-> fin[i]);

        // R6
        invalid_keeps_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(valid[i]) |-> $stable(width[i]));
    end
endmodule

bind rc_pulse_decoder rcpd_checker #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_rcpd_chk (
    .clk(clk), .rst_n(rst_n), .fin(fin), .width(width_o), .valid(valid_o),
    .off_grid(off_grid_o), .frame_done(frame_done_o)
);

// File: tb/rc_pulse_decoder_test.sv
module rc_pulse_decoder_test;
    localparam int NCH = 8;
    localparam int CPU = 4;
    localparam int TW  = 16;
    localparam int GRID = 60;
    localparam int TOL = 2;
    localparam int MAXH = 300;
    localparam int RTO = 3000;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NCH-1:0]           pulse_in = '0;
    logic [NCH-1:0][TW-1:0]   width_o;
    logic [NCH-1:0]           valid_o;
    logic [NCH-1:0]           off_grid_o;
    logic                     frame_done_o;

    rc_pulse_decoder #(.NUM_CH(NCH), .CLK_PER_US(CPU), .TS_W(TW), .GRID_US(GRID),
        .GRID_TOL_US(TOL), .MAX_HIGH_US(MAXH), .RISE_TIMEOUT_US(RTO)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .width_o(width_o),
        .valid_o(valid_o), .off_grid_o(off_grid_o), .frame_done_o(frame_done_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int w [NCH];
        bit v [NCH];
        bit og [NCH];
        int t_min;
    } exp_t;

    exp_t sb [$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int us_now = 0;
    int frames_seen = 0;
    bit prev_done = 1'b0;
    bit finished = 1'b0;
    int exp_w [NCH];
    bit exp_og [NCH];
    int last_fall [NCH];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc++;

    // Monitor: pops expected frame records on each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(frame_done_o && prev_done), "R8", "strobe longer than one cycle", 1, 0);
            if (frame_done_o) begin
                frames_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected frame strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk((cyc / CPU) >= e.t_min && (cyc / CPU) <= e.t_min + 2,
                        "R8", "strobe time us", cyc / CPU, e.t_min);
                    for (int i = 0; i < NCH; i++) begin
                        chk(int'(width_o[i]) == e.w[i], "R1", $sformatf("width ch%0d", i),
                            int'(width_o[i]), e.w[i]);
                        chk(valid_o[i] == e.v[i], "R6", $sformatf("valid ch%0d", i),
                            int'(valid_o[i]), int'(e.v[i]));
                        chk(off_grid_o[i] == e.og[i], "R3", $sformatf("off-grid ch%0d", i),
                            int'(off_grid_o[i]), int'(e.og[i]));
                    end
                end
            end
            prev_done = frame_done_o;
        end
    end

    task automatic wait_us(input int n);
        repeat (n * CPU) @(posedge clk);
        #1;
        us_now += n;
    endtask

    // Driver: pushes expectations, then plays one frame. st < 0 means no rise.
    task automatic run_frame(input int st [NCH], input int en [NCH], input int hold);
        exp_t e;
        int base, len;
        base = ((us_now + GRID - 1) / GRID) * GRID;
        if (base > us_now) wait_us(base - us_now);
        len = hold;
        e.t_min = 0;
        for (int i = 0; i < NCH; i++) begin
            int tf;
            if (en[i] > len) len = en[i];
            if (st[i] < 0) begin
                tf = last_fall[i] + RTO;
                e.v[i] = 1'b0;
            end else if (en[i] - st[i] > MAXH) begin
                tf = base + st[i] + MAXH + 1;
                e.v[i] = 1'b0;
                last_fall[i] = base + en[i];
            end else begin
                int ph;
                tf = base + en[i];
                e.v[i] = 1'b1;
                exp_w[i] = en[i] - st[i];
                ph = (base + en[i]) % GRID;
                exp_og[i] = (ph > TOL) && (ph < GRID - TOL);
                last_fall[i] = base + en[i];
            end
            e.w[i] = exp_w[i];
            e.og[i] = exp_og[i];
            if (tf > e.t_min) e.t_min = tf;
        end
        sb.push_back(e);
        for (int t = 0; t <= len; t++) begin
            for (int i = 0; i < NCH; i++)
                pulse_in[i] = (st[i] >= 0) && (t >= st[i]) && (t < en[i]);
            wait_us(1);
        end
        pulse_in = '0;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            exp_w[i] = 0; exp_og[i] = 1'b0; last_fall[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(width_o == '0, "R9", "widths after reset", 0, 0);
        chk(valid_o == '0, "R9", "valid after reset", int'(valid_o), 0);
        chk(off_grid_o == '0, "R9", "off-grid after reset", int'(off_grid_o), 0);
        chk(frame_done_o == 1'b0, "R9", "strobe after reset", int'(frame_done_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2 R4 R5: 17 us start spacing, out-of-order ends, shared ends
        run_frame('{100, 117, 200, 217, 300, 317, 400, 417},
                  '{360, 300, 420, 420, 540, 480, 600, 480}, 0);
        // R3: ch3 ends 10 us past a boundary
        run_frame('{110, 127, 190, 207, 310, 327, 380, 397},
                  '{300, 240, 420, 430, 480, 420, 540, 600}, 0);
        // R6: ch5 stays high 403 us
        run_frame('{100, 117, 200, 217, 300, 317, 400, 417},
                  '{360, 300, 420, 420, 540, 720, 600, 480}, 0);
        // R7: ch2 never rises
        run_frame('{100, 117, -1, 217, 300, 317, 400, 417},
                  '{360, 300, 0, 420, 540, 480, 600, 480}, 2760);
        // R1: recovery to valid on every channel
        run_frame('{100, 117, 200, 217, 300, 317, 400, 417},
                  '{360, 300, 420, 420, 540, 480, 600, 480}, 0);
        wait_us(20);
        chk(frames_seen == 5, "R8", "frame strobes seen", frames_seen, 5);
        chk(sb.size() == 0, "R8", "frames left unmatched", sb.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule